// File: doc/BRIEF.md
# Page Write and Address Pointer Controller

This block sits behind a two-wire serial slave front end and owns the data path of a small byte-addressed store. The front end decodes bus traffic and presents single-cycle strobes. A word-address byte starts a write frame. Each following data byte is collected in a page buffer. STOP closes the frame, and a read request asks for the next byte. Another strobe arms the one-time protection fuse. A register array stands in for the nonvolatile cells.

Write data is held in the page buffer and reaches the array only when STOP arrives. That STOP then opens a timed write window, and the controller accepts no traffic for the length of it. A single address pointer serves writes and current-address, random and sequential reads, and it wraps at the top of the array. The array holds either 128 bytes (`ADDR_W`=7) or 256 bytes (`ADDR_W`=8). Once the fuse is set, it guards the whole 128-byte array, or the lower half (addresses below 80h) of the 256-byte array.

Top module: `pagewr_ctrl`

## Requirements
- R1: After reset `busy_o`, `rd_vld_o` and `fuse_o` are 0, the pointer is 0, and every array byte reads as 00h.
- R2: An address strobe loads the pointer and the frame base with `byte_i`. Data bytes are buffered, and at STOP the byte with index j (counted from 0) is written to address (base + j) mod array size.
- R3: A STOP that commits at least one data byte or a fuse setting raises `busy_o` in the next cycle. `busy_o` then stays high for exactly `WC_CYCLES` cycles.
- R4: The buffer holds `PAGE`=16 slots. Data byte j goes to slot j mod 16, which maps to address base + (j mod 16), so a later byte overwrites an earlier one.
- R5: The pointer advances by one for every accepted data byte and every read byte. It wraps from 7Fh (`ADDR_W`=7) or FFh (`ADDR_W`=8) to 00h.
- R6: A read request returns the byte at the pointer on `rd_data_o`, with `rd_vld_o` high for one cycle in the next cycle. Back-to-back requests return consecutive addresses.
- R7: A STOP after a frame with no data bytes (random-read address setup) changes only the pointer and does not raise `busy_o`.
- R8: A fuse request followed by STOP sets `fuse_o` permanently and starts a write window. A fuse request after the fuse is set is ignored, and its STOP does not raise `busy_o`.
- R9: While `fuse_o` is 1, buffered bytes addressed to the protected zone are dropped at commit, but the write window still runs. The zone is every address when `ADDR_W`=7 and addresses below 80h when `ADDR_W`=8.
- R10: While `busy_o` is high, every strobe is ignored: no read data, no pointer change, no buffering.
- R11: A read request while data bytes are pending discards them, so a later STOP commits nothing and does not raise `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld_i | input | 1 | Word-address byte of a write frame on `byte_i` |
| data_vld_i | input | 1 | Data byte of a write frame on `byte_i` |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | STOP seen on the bus |
| rd_req_i | input | 1 | Request for the next read byte |
| fuse_req_i | input | 1 | Set-protection command received |
| busy_o | output | 1 | Internal write window in progress |
| rd_vld_o | output | 1 | `rd_data_o` carries a fresh read byte |
| rd_data_o | output | 8 | Read byte |
| fuse_o | output | 1 | Protection fuse is set |

## Verification
The hardest case to reach from the ports is protection that splits a single page. A frame has to begin below 80h, run across the zone edge, and commit after the fuse is set. The read-back must then show old contents on one side of the edge and new contents on the other, while the write window still runs for the full length. The stimulus reaches this by first blowing the fuse through a request and STOP. It waits out that window, writes a frame from 7Eh across 80h, and re-reads the range. A second instance built with a 128-byte array is held in reset until the end. It then runs its own pointer wrap at 7Fh and its whole-array protection.

// File: rtl/pagewr_pkg.sv
`timescale 1ns/1ps
package pagewr_pkg;

    // One accepted bus event per cycle, at most one field set.
    typedef struct packed {
        logic load_addr;
        logic push_data;
        logic close;
        logic read;
        logic arm_fuse;
    } ev_t;

    // Fuse zone: every byte of a 128-byte array, lower half of larger arrays.
    function automatic bit in_fuse_zone(input int unsigned addr, input int unsigned aw);
        if (aw <= 7)
            return 1'b1;
        return addr < (32'd1 << (aw - 1));
    endfunction

    // Priority decode of front-end strobes; nothing passes while busy.
    function automatic ev_t decode_ev(input logic idle, input logic addr, input logic data,
                                      input logic stop, input logic rd, input logic fuse);
        ev_t e;
        e = '0;
        if (idle) begin
            if (stop)       e.close     = 1'b1;
            else if (addr)  e.load_addr = 1'b1;
            else if (data)  e.push_data = 1'b1;
            else if (rd)    e.read      = 1'b1;
            else if (fuse)  e.arm_fuse  = 1'b1;
        end
        return e;
    endfunction

endpackage

// File: rtl/pagewr_buffer.sv
`timescale 1ns/1ps
module pagewr_buffer #(
    parameter int PAGE   = 16,
    parameter int SLOT_W = $clog2(PAGE),
    parameter int FILL_W = $clog2(PAGE + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_i,
    input  logic                push_i,
    input  logic [7:0]          din_i,
    output logic [FILL_W-1:0]   fill_o,
    output logic [PAGE*8-1:0]   slots_o
);

    logic [7:0]        slot_q [PAGE];
    logic [SLOT_W-1:0] wr_idx_q;
    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            wr_idx_q <= '0;
            fill_q   <= '0;
        end else if (push_i) begin
            slot_q[wr_idx_q] <= din_i;
            wr_idx_q         <= wr_idx_q + 1'b1;
            if (fill_q != FILL_W'(PAGE))
                fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar s = 0; s < PAGE; s++) begin : g_slot
        assign slots_o[s*8 +: 8] = slot_q[s];
    end

    assign fill_o = fill_q;

    // Once full, further pushes overwrite slots without growing the count.
    assert_fill_sat_R4: assert property (@(posedge clk) disable iff (rst)
        (push_i && !clear_i && fill_q == FILL_W'(PAGE)) |=> fill_q == FILL_W'(PAGE));

endmodule

// File: rtl/pagewr_timer.sv
`timescale 1ns/1ps
module pagewr_timer #(
    parameter int WC_CYCLES = 1250000,
    parameter int CNT_W     = $clog2(WC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (start_i)
            left_q <= CNT_W'(WC_CYCLES);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

endmodule

// File: rtl/pagewr_array.sv
`timescale 1ns/1ps
module pagewr_array import pagewr_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int PAGE   = 16,
    parameter int SIZE   = 1 << ADDR_W,
    parameter int SLOT_W = $clog2(PAGE),
    parameter int FILL_W = $clog2(PAGE + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [FILL_W-1:0]   fill_i,
    input  logic [PAGE*8-1:0]   slots_i,
    input  logic                fuse_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [7:0]          rd_byte_o
);

    logic [7:0] cell_w [SIZE];

    for (genvar a = 0; a < SIZE; a++) begin : g_cell
        localparam bit ZONE = in_fuse_zone(a, ADDR_W);
        logic [7:0]        cell_q;
        logic [ADDR_W-1:0] off;
        logic              hit;

        assign off = ADDR_W'(a) - base_i;
        assign hit = commit_i && ({1'b0, off} < (ADDR_W+1)'(fill_i))
                     && !(fuse_i && ZONE);

        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (hit)
                cell_q <= slots_i[off[SLOT_W-1:0]*8 +: 8];
        end

        assign cell_w[a] = cell_q;
    end

    assign rd_byte_o = cell_w[rd_addr_i];

    // Address 0 is inside the zone for every size: a commit under the fuse leaves it.
    assert_zone_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fuse_i && commit_i) |=> $stable(cell_w[0]));

endmodule

// File: rtl/pagewr_ctrl.sv
`timescale 1ns/1ps
module pagewr_ctrl import pagewr_pkg::*; #(
    parameter int ADDR_W    = 8,
    parameter int PAGE      = 16,
    parameter int WC_CYCLES = 1250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_vld_i,
    input  logic       data_vld_i,
    input  logic [7:0] byte_i,
    input  logic       stop_i,
    input  logic       rd_req_i,
    input  logic       fuse_req_i,
    output logic       busy_o,
    output logic       rd_vld_o,
    output logic [7:0] rd_data_o,
    output logic       fuse_o
);

    localparam int SIZE   = 1 << ADDR_W;
    localparam int SLOT_W = $clog2(PAGE);
    localparam int FILL_W = $clog2(PAGE + 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(SIZE - 1);

    ev_t               ev;
    logic [ADDR_W-1:0] ptr_q, base_q;
    logic              fuse_q, fuse_arm_q;
    logic              rd_vld_q;
    logic [7:0]        rd_data_q, rd_byte;
    logic [FILL_W-1:0] fill;
    logic [PAGE*8-1:0] slots;
    logic              commit_data, commit_fuse, wc_start, buf_clear;

    assign ev = decode_ev(!busy_o, addr_vld_i, data_vld_i, stop_i, rd_req_i, fuse_req_i);

    assign commit_data = ev.close && (fill != '0);
    assign commit_fuse = ev.close && fuse_arm_q && !fuse_q;
    assign wc_start    = commit_data || commit_fuse;
    assign buf_clear   = ev.close || ev.load_addr || ev.read;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            base_q     <= '0;
            fuse_q     <= 1'b0;
            fuse_arm_q <= 1'b0;
            rd_vld_q   <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_vld_q <= 1'b0;
            if (ev.load_addr) begin
                ptr_q  <= byte_i[ADDR_W-1:0];
                base_q <= byte_i[ADDR_W-1:0];
            end
            if (ev.push_data)
                ptr_q <= ptr_q + 1'b1;
            if (ev.read) begin
                rd_data_q <= rd_byte;
                rd_vld_q  <= 1'b1;
                ptr_q     <= ptr_q + 1'b1;
            end
            if (ev.arm_fuse && !fuse_q)
                fuse_arm_q <= 1'b1;
            if (ev.close || ev.read)
                fuse_arm_q <= 1'b0;
            if (commit_fuse)
                fuse_q <= 1'b1;
        end
    end

    pagewr_buffer #(.PAGE(PAGE)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (buf_clear),
        .push_i  (ev.push_data),
        .din_i   (byte_i),
        .fill_o  (fill),
        .slots_o (slots)
    );

    pagewr_array #(.ADDR_W(ADDR_W), .PAGE(PAGE)) array_i (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit_data),
        .base_i    (base_q),
        .fill_i    (fill),
        .slots_i   (slots),
        .fuse_i    (fuse_q),
        .rd_addr_i (ptr_q),
        .rd_byte_o (rd_byte)
    );

    pagewr_timer #(.WC_CYCLES(WC_CYCLES)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (wc_start),
        .busy_o  (busy_o)
    );

    assign rd_vld_o  = rd_vld_q;
    assign rd_data_o = rd_data_q;
    assign fuse_o    = fuse_q;

    assert_fuse_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fuse_o |=> fuse_o);

    assert_busy_deaf_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && rd_req_i) |=> !rd_vld_o);

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && rd_req_i && !stop_i && !addr_vld_i && !data_vld_i && ptr_q == TOP_ADDR)
        |=> ptr_q == '0);

    assert_empty_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && stop_i && fill == '0 && !fuse_arm_q) |=> !busy_o);

endmodule

// File: tb/pagewr_ctrl_tb_top.sv
`timescale 1ns/1ps
module pagewr_ctrl_tb_top;

    localparam int WC = 20;
    localparam int SZ = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en7 = 1'b0;
    logic addr_vld = 0, data_vld = 0, stop = 0, rd_req = 0, fuse_req = 0;
    logic [7:0] byte_in = '0;

    logic busy, rd_vld, fuse;
    logic [7:0] rd_data;
    logic busy7, rd_vld7, fuse7;
    logic [7:0] rd_data7;
    logic rst7;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string phase = "R1 reset";

    always #4 clk = ~clk;

    assign rst7 = rst || !en7;

    pagewr_ctrl #(.ADDR_W(8), .PAGE(16), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst(rst), .addr_vld_i(addr_vld), .data_vld_i(data_vld),
        .byte_i(byte_in), .stop_i(stop), .rd_req_i(rd_req), .fuse_req_i(fuse_req),
        .busy_o(busy), .rd_vld_o(rd_vld), .rd_data_o(rd_data), .fuse_o(fuse));

    pagewr_ctrl #(.ADDR_W(7), .PAGE(16), .WC_CYCLES(WC)) dut7_i (
        .clk(clk), .rst(rst7), .addr_vld_i(addr_vld), .data_vld_i(data_vld),
        .byte_i(byte_in), .stop_i(stop), .rd_req_i(rd_req), .fuse_req_i(fuse_req),
        .busy_o(busy7), .rd_vld_o(rd_vld7), .rd_data_o(rd_data7), .fuse_o(fuse7));

    // Behavioural reference for the 256-byte instance.
    int m_mem [SZ];
    int m_ptr, m_base, m_n, m_busy, m_rdd;
    bit m_rdv, m_fuse, m_arm;
    int q [$];

    always @(posedge clk) begin
        bit was_busy;
        bit go;
        int j;
        int a;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_ptr = 0; m_base = 0; m_n = 0; m_busy = 0; m_rdd = 0;
            m_rdv = 0; m_fuse = 0; m_arm = 0;
            q.delete();
        end else begin
            was_busy = (m_busy != 0);
            if (m_busy > 0) m_busy--;
            m_rdv = 0;
            if (!was_busy) begin
                if (stop) begin
                    go = 0;
                    if (q.size() > 0) begin
                        foreach (q[i]) begin
                            j = m_n - q.size() + i;
                            a = (m_base + (j % 16)) % SZ;
                            if (!(m_fuse && a < 128)) m_mem[a] = q[i];
                        end
                        go = 1;
                    end
                    if (m_arm && !m_fuse) begin
                        m_fuse = 1;
                        go = 1;
                    end
                    if (go) m_busy = WC;
                    q.delete(); m_n = 0; m_arm = 0;
                end else if (addr_vld) begin
                    m_base = byte_in; m_ptr = byte_in;
                    q.delete(); m_n = 0;
                end else if (data_vld) begin
                    q.push_back(byte_in);
                    if (q.size() > 16) void'(q.pop_front());
                    m_n++;
                    m_ptr = (m_ptr + 1) % SZ;
                end else if (rd_req) begin
                    m_rdd = m_mem[m_ptr]; m_rdv = 1;
                    m_ptr = (m_ptr + 1) % SZ;
                    q.delete(); m_n = 0; m_arm = 0;
                end else if (fuse_req) begin
                    if (!m_fuse) m_arm = 1;
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check({phase, " busy R3"}, busy, m_busy != 0);
            check({phase, " rd_vld R6"}, rd_vld, m_rdv);
            if (m_rdv) check({phase, " rd_data R6"}, rd_data, m_rdd);
            check({phase, " fuse R8"}, fuse, m_fuse);
        end
    end

    // kind: 0 addr, 1 data, 2 stop, 3 read, 4 fuse
    task automatic strobe(input int kind, input int val);
        @(negedge clk);
        byte_in = 8'(val);
        case (kind)
            0: addr_vld = 1;
            1: data_vld = 1;
            2: stop = 1;
            3: rd_req = 1;
            default: fuse_req = 1;
        endcase
        @(negedge clk);
        addr_vld = 0; data_vld = 0; stop = 0; rd_req = 0; fuse_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_from(input int a, input int cnt);
        strobe(0, a);
        strobe(2, 0);
        for (int k = 0; k < cnt; k++) strobe(3, 0);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst = 0;
        // R1: reset values and zero memory at address 0
        phase = "R1 reset";
        check("R1 busy", busy, 0);
        check("R1 fuse", fuse, 0);
        strobe(3, 0);
        check("R1 first read", rd_data, 0);

        // R2: short write from 10h, committed at STOP
        phase = "R2 byte write";
        strobe(0, 8'h10);
        strobe(1, 8'hA1); strobe(1, 8'hB2); strobe(1, 8'hC3);
        strobe(2, 0);
        idle(WC + 4);
        // R7 + R6: address-only frame, then sequential read
        phase = "R7 R6 random read";
        read_from(8'h10, 4);

        // R4: 20 data bytes wrap inside the 16-slot buffer
        phase = "R4 page overflow";
        strobe(0, 8'h40);
        for (int k = 0; k < 20; k++) strobe(1, 8'h60 + k);
        strobe(2, 0);
        idle(WC + 4);
        read_from(8'h40, 17);

        // R5: commit and read across FFh -> 00h
        phase = "R5 wrap 256";
        strobe(0, 8'hFE);
        strobe(1, 8'h11); strobe(1, 8'h22); strobe(1, 8'h33);
        strobe(2, 0);
        // R10: strobes during the write window are ignored
        phase = "R10 busy ignore";
        strobe(3, 0);
        strobe(0, 8'h05);
        strobe(1, 8'h99);
        idle(WC + 4);
        phase = "R5 wrap read";
        strobe(3, 0);
        read_from(8'hFE, 4);

        // R11: read while data is pending discards it
        phase = "R11 pending discard";
        strobe(0, 8'h20);
        strobe(1, 8'h77);
        strobe(3, 0);
        strobe(2, 0);
        idle(3);
        read_from(8'h20, 1);

        // R8: set the fuse
        phase = "R8 fuse set";
        strobe(4, 0);
        strobe(2, 0);
        idle(WC + 4);
        // R9: frame spanning the zone edge at 80h
        phase = "R9 lower half";
        strobe(0, 8'h7E);
        for (int k = 0; k < 4; k++) strobe(1, 8'hE0 + k);
        strobe(2, 0);
        idle(WC + 4);
        read_from(8'h7C, 7);
        // R8: second fuse request ignored
        phase = "R8 fuse again";
        strobe(4, 0);
        strobe(2, 0);
        idle(4);

        // 128-byte instance: wrap at 7Fh and whole-array protection
        phase = "R5 R9 small array";
        @(negedge clk) en7 = 1;
        idle(2);
        strobe(0, 8'h7F); strobe(1, 8'h5A); strobe(2, 0);
        check("R3 small busy", busy7, 1);
        idle(WC + 4);
        strobe(0, 8'h7F); strobe(2, 0);
        check("R7 small no busy", busy7, 0);
        strobe(3, 0);
        check("R6 small vld", rd_vld7, 1);
        check("R6 small data", rd_data7, 8'h5A);
        strobe(3, 0);
        check("R5 small wrap data", rd_data7, 8'h00);
        strobe(4, 0); strobe(2, 0);
        check("R8 small busy", busy7, 1);
        idle(WC + 4);
        check("R8 small fuse", fuse7, 1);
        strobe(0, 8'h10); strobe(1, 8'h33); strobe(2, 0);
        check("R9 small window runs", busy7, 1);
        idle(WC + 4);
        strobe(0, 8'h10); strobe(2, 0); strobe(3, 0);
        check("R9 small protected", rd_data7, 8'h00);

        idle(4);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule